// File: doc/BRIEF.md
# Dual-Channel I/Q Output Formatter

This block takes in-phase and quadrature sample pairs from an upstream pipeline and puts them on two output buses of `W` bits each (10 by default). In parallel mode each bus carries a whole word, with the most significant bit on bus bit `W-1`. A data-ready pin marks the single cycle in which a new pair first appears. In serial mode the words are sent one bit at a time, most significant bit first, on bit 0 of each bus. Bit `W-1` of the in-phase bus carries a serial clock at half the core clock rate. Every other bus bit is driven to a static fill level taken from configuration.

Samples come in on a valid-only input. The input has no ready signal and never back-pressures. In parallel mode every valid pair is taken on the edge where it is presented. In serial mode one pair can wait in a single holding slot while a word is being shifted. A newer arrival overwrites the held pair, so the output always moves on to the freshest pending sample. A configuration bit sets the active level of data-ready in both modes. Each bus has an active-low enable that the block turns into a per-bus pad drive enable. All configuration inputs are meant to stay static while traffic flows. The serial engine is cleared whenever parallel mode is selected.

Top module: `iq_out_formatter`

## Requirements
- R1: In parallel mode a pair presented with `in_valid` high at a rising edge appears on `out_i`/`out_q` (MSB on bit W-1) right after that edge, and data-ready is active in that same cycle.
- R2: In parallel mode data-ready is active for exactly one cycle per accepted pair. The buses keep the last pair while no new one arrives.
- R3: `out_rdy` is high when data-ready is active if `cfg_rdy_hi`=1, and low when it is active if `cfg_rdy_hi`=0. This holds in both modes.
- R4: In serial mode `out_i[0]` and `out_q[0]` carry the word MSB first. Each bit is held for two clock cycles and changes only where the serial clock falls. The data pins are 0 when no word is being shifted.
- R5: In serial mode data-ready is active for exactly one serial clock period (two cycles, serial clock low then high), ending at the falling edge where the MSB appears.
- R6: In serial mode `out_i[W-1]` is a serial clock that is 0 while reset is held and toggles on every clock edge after that.
- R7: In serial mode `out_i[W-2:1]` follow `cfg_fill_i[W-2:1]` and `out_q[W-1:1]` follow `cfg_fill_q[W-1:1]`.
- R8: A pair that arrives while a serial word is in progress is held. Its data-ready period starts at the falling edge right after the last bit of the current word.
- R9: If a second pair arrives while one is held, the held one is discarded and only the newest is sent.
- R10: `out_i_en` is 0 while `oe_i_n` is 1 and 1 otherwise. `out_q_en` follows `oe_q_n` in the same way. Each enable is independent of the other.
- R11: While reset is held in parallel mode both buses read 0 and data-ready is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| in_valid | input | 1 | New sample pair present (no back-pressure) |
| in_i | input | W | In-phase sample |
| in_q | input | W | Quadrature sample |
| cfg_serial | input | 1 | 1 = bit-serial output, 0 = parallel |
| cfg_rdy_hi | input | 1 | 1 = data-ready active high, 0 = active low |
| cfg_fill_i | input | W | Levels for the unused in-phase pins in serial mode |
| cfg_fill_q | input | W | Levels for the unused quadrature pins in serial mode |
| oe_i_n | input | 1 | Active-low enable for the in-phase bus |
| oe_q_n | input | 1 | Active-low enable for the quadrature bus |
| out_i | output | W | In-phase bus |
| out_q | output | W | Quadrature bus |
| out_rdy | output | 1 | Data-ready pin |
| out_i_en | output | 1 | Pad drive enable for the in-phase bus |
| out_q_en | output | 1 | Pad drive enable for the quadrature bus |

## Verification
Parallel mode is driven with a random valid pattern and random words. Gaps and back-to-back arrivals show whether data-ready pulses once per pair and whether the bus holds between pairs. Serial mode is tried with isolated words, including alternating-bit patterns that expose MSB/LSB swaps and bit slips. A second arrival during a shift shows that the held pair follows at once. A third arrival shows that the older held pair is dropped rather than queued. Active-low ready, fill levels and the per-bus enables are each flipped on their own so that any crossed wiring shows up.

// File: rtl/iqf_pkg.sv
package iqf_pkg;
  typedef enum logic [1:0] {
    SER_IDLE  = 2'd0,
    SER_ANN   = 2'd1,
    SER_SHIFT = 2'd2
  } ser_st_t;
endpackage

// File: rtl/iqf_par.sv
module iqf_par #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         in_valid,
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] in_q,
  output logic [W-1:0] par_i,
  output logic [W-1:0] par_q,
  output logic         par_rdy
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_i   <= '0;
      par_q   <= '0;
      par_rdy <= 1'b0;
    end else begin
      par_rdy <= en && in_valid;
      if (en && in_valid) begin
        par_i <= in_i;
        par_q <= in_q;
      end
    end
  end

  // R1
  par_new_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_valid) |=> par_rdy);

  // R2
  par_single_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid) |=> (!par_rdy && $stable(par_i) && $stable(par_q)));
endmodule

// File: rtl/iqf_ser.sv
module iqf_ser
  import iqf_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         in_valid,
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] in_q,
  output logic         sclk,
  output logic         sd_i,
  output logic         sd_q,
  output logic         ser_rdy
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

  logic          ph;
  ser_st_t       st;
  logic [IW-1:0] idx;
  logic [W-1:0]  sh_i, sh_q;
  logic          pend_v;
  logic [W-1:0]  pend_i, pend_q;
  logic          fall, last_bit, load;

  assign fall     = ph;
  assign last_bit = (st == SER_SHIFT) && (idx == '0);
  assign load     = fall && pend_v && ((st == SER_IDLE) || last_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) ph <= 1'b0;
    else        ph <= ~ph;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      pend_v <= 1'b0;
      pend_i <= '0;
      pend_q <= '0;
    end else if (in_valid) begin
      pend_v <= 1'b1;
      pend_i <= in_i;
      pend_q <= in_q;
    end else if (load) begin
      pend_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      st   <= SER_IDLE;
      idx  <= '0;
      sh_i <= '0;
      sh_q <= '0;
    end else if (fall) begin
      if (load) begin
        sh_i <= pend_i;
        sh_q <= pend_q;
      end
      unique case (st)
        SER_IDLE:  if (pend_v) st <= SER_ANN;
        SER_ANN: begin
          st  <= SER_SHIFT;
          idx <= TOP_IDX;
        end
        SER_SHIFT: begin
          if (idx != '0) idx <= idx - 1'b1;
          else           st  <= pend_v ? SER_ANN : SER_IDLE;
        end
        default: st <= SER_IDLE;
      endcase
    end
  end

  assign sclk    = ph;
  assign sd_i    = (st == SER_SHIFT) ? sh_i[idx] : 1'b0;
  assign sd_q    = (st == SER_SHIFT) ? sh_q[idx] : 1'b0;
  assign ser_rdy = (st == SER_ANN);

  // R4
  ser_data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sclk) |=> ($stable(sd_i) && $stable(sd_q)));

  // R5
  ser_rdy_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_rdy) |=> ser_rdy);

  // R5
  ser_rdy_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_rdy && $past(ser_rdy)) |=> !ser_rdy);
endmodule

// File: rtl/iqf_pads.sv
module iqf_pads #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_serial,
  input  logic         cfg_rdy_hi,
  input  logic [W-1:0] cfg_fill_i,
  input  logic [W-1:0] cfg_fill_q,
  input  logic         oe_i_n,
  input  logic         oe_q_n,
  input  logic [W-1:0] par_i,
  input  logic [W-1:0] par_q,
  input  logic         par_rdy,
  input  logic         sclk,
  input  logic         sd_i,
  input  logic         sd_q,
  input  logic         ser_rdy,
  output logic [W-1:0] out_i,
  output logic [W-1:0] out_q,
  output logic         out_rdy,
  output logic         out_i_en,
  output logic         out_q_en
);
  logic rdy_act;

  always_comb begin
    for (int b = 0; b < W; b++) begin
      if (!cfg_serial) begin
        out_i[b] = par_i[b];
        out_q[b] = par_q[b];
      end else begin
        out_i[b] = (b == 0) ? sd_i : (b == W - 1) ? sclk : cfg_fill_i[b];
        out_q[b] = (b == 0) ? sd_q : cfg_fill_q[b];
      end
    end
  end

  assign rdy_act  = cfg_serial ? ser_rdy : par_rdy;
  assign out_rdy  = cfg_rdy_hi ? rdy_act : ~rdy_act;
  assign out_i_en = ~oe_i_n;
  assign out_q_en = ~oe_q_n;

  // R6
  ser_clk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_serial && $past(cfg_serial)) |-> (out_i[W-1] != $past(out_i[W-1])));
endmodule

// File: rtl/iq_out_formatter.sv
module iq_out_formatter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] in_q,
  input  logic         cfg_serial,
  input  logic         cfg_rdy_hi,
  input  logic [W-1:0] cfg_fill_i,
  input  logic [W-1:0] cfg_fill_q,
  input  logic         oe_i_n,
  input  logic         oe_q_n,
  output logic [W-1:0] out_i,
  output logic [W-1:0] out_q,
  output logic         out_rdy,
  output logic         out_i_en,
  output logic         out_q_en
);
  logic [W-1:0] par_i, par_q;
  logic         par_rdy, sclk, sd_i, sd_q, ser_rdy;

  iqf_par #(.W(W)) u_par (
    .clk(clk), .rst_n(rst_n), .en(!cfg_serial), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q), .par_i(par_i), .par_q(par_q), .par_rdy(par_rdy)
  );

  iqf_ser #(.W(W)) u_ser (
    .clk(clk), .rst_n(rst_n), .en(cfg_serial), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q), .sclk(sclk), .sd_i(sd_i), .sd_q(sd_q),
    .ser_rdy(ser_rdy)
  );

  iqf_pads #(.W(W)) u_pads (
    .clk(clk), .rst_n(rst_n), .cfg_serial(cfg_serial), .cfg_rdy_hi(cfg_rdy_hi),
    .cfg_fill_i(cfg_fill_i), .cfg_fill_q(cfg_fill_q),
    .oe_i_n(oe_i_n), .oe_q_n(oe_q_n),
    .par_i(par_i), .par_q(par_q), .par_rdy(par_rdy),
    .sclk(sclk), .sd_i(sd_i), .sd_q(sd_q), .ser_rdy(ser_rdy),
    .out_i(out_i), .out_q(out_q), .out_rdy(out_rdy),
    .out_i_en(out_i_en), .out_q_en(out_q_en)
  );
endmodule

// File: tb/sim_iq_out_formatter.sv
module sim_iq_out_formatter;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_i = '0, in_q = '0;
  logic         cfg_serial = 1'b0, cfg_rdy_hi = 1'b1;
  logic [W-1:0] cfg_fill_i = 10'h15A, cfg_fill_q = 10'h2A5;
  logic         oe_i_n = 1'b0, oe_q_n = 1'b0;
  logic [W-1:0] out_i, out_q;
  logic         out_rdy, out_i_en, out_q_en;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  iq_out_formatter #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .cfg_serial(cfg_serial), .cfg_rdy_hi(cfg_rdy_hi),
    .cfg_fill_i(cfg_fill_i), .cfg_fill_q(cfg_fill_q),
    .oe_i_n(oe_i_n), .oe_q_n(oe_q_n), .out_i(out_i), .out_q(out_q),
    .out_rdy(out_rdy), .out_i_en(out_i_en), .out_q_en(out_q_en)
  );

  function automatic logic rdy_active(logic pin, logic hi);
    return hi ? pin : ~pin;
  endfunction

  function automatic logic [W-1:0] fill_exp_i(logic [W-1:0] f);
    logic [W-1:0] r = f;
    r[0] = 1'b0; r[W-1] = 1'b0;
    return r;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Expect one serial word; entry is at a negedge, first action advances one cycle.
  task automatic ser_word(input logic [W-1:0] ei, input logic [W-1:0] eq,
                          input bit immediate);
    int waitc = 0;
    @(negedge clk);
    in_valid = 1'b0;
    if (!immediate) begin
      while (!rdy_active(out_rdy, cfg_rdy_hi) && waitc < 20) begin
        @(negedge clk);
        waitc++;
      end
    end
    chk(rdy_active(out_rdy, cfg_rdy_hi), immediate ? "R8 rdy right after word" : "R5 rdy start",
        out_rdy, cfg_rdy_hi);
    chk(out_i[W-1] == 1'b0, "R5 rdy starts with sclk low", out_i[W-1], 0);
    @(negedge clk);
    chk(rdy_active(out_rdy, cfg_rdy_hi) && out_i[W-1], "R5 rdy second cycle",
        {out_rdy, out_i[W-1]}, {cfg_rdy_hi, 1'b1});
    for (int b = W - 1; b >= 0; b--) begin
      for (int h = 0; h < 2; h++) begin
        @(negedge clk);
        chk(out_i[0] == ei[b], "R4 I serial bit", out_i[0], ei[b]);
        chk(out_q[0] == eq[b], "R4 Q serial bit", out_q[0], eq[b]);
        chk(out_i[W-1] == logic'(h), "R6 sclk phase", out_i[W-1], h);
        chk(!rdy_active(out_rdy, cfg_rdy_hi), "R5 rdy off during shift", out_rdy, !cfg_rdy_hi);
      end
    end
  endtask

  task automatic expect_ser_idle(input string tag);
    @(negedge clk);
    chk(!rdy_active(out_rdy, cfg_rdy_hi) && out_i[0] == 1'b0 && out_q[0] == 1'b0,
        tag, {out_rdy, out_i[0], out_q[0]}, {!cfg_rdy_hi, 2'b00});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] ei, eq, bi, bq, ci, cq;
    logic         erdy;
    void'($urandom(32'h1234_5678));

    // R11 reset state
    repeat (3) @(negedge clk);
    chk(out_i == '0 && out_q == '0, "R11 buses zero in reset", {out_i, out_q}, 0);
    chk(!rdy_active(out_rdy, 1'b1), "R11 rdy inactive in reset", out_rdy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 directed parallel
    in_valid = 1'b1; in_i = 10'h3FF; in_q = 10'h001;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_i == 10'h3FF && out_q == 10'h001, "R1 parallel word", {out_i, out_q}, {10'h3FF, 10'h001});
    chk(out_rdy == 1'b1, "R1 rdy with new word", out_rdy, 1);
    @(negedge clk);
    chk(out_rdy == 1'b0, "R2 rdy one cycle", out_rdy, 0);
    chk(out_i == 10'h3FF && out_q == 10'h001, "R2 bus holds", {out_i, out_q}, {10'h3FF, 10'h001});

    // R1/R2 random parallel traffic
    ei = 10'h3FF; eq = 10'h001; erdy = 1'b0;
    for (int n = 0; n < 300; n++) begin
      in_valid = ($urandom % 3) != 0;
      in_i = W'($urandom); in_q = W'($urandom);
      if (in_valid) begin ei = in_i; eq = in_q; end
      erdy = in_valid;
      @(negedge clk);
      chk(out_i == ei && out_q == eq, "R1 random parallel data", {out_i, out_q}, {ei, eq});
      chk(out_rdy == erdy, "R2 random parallel rdy", out_rdy, erdy);
    end
    in_valid = 1'b0;
    @(negedge clk);

    // R3 active-low ready in parallel
    cfg_rdy_hi = 1'b0;
    #1 chk(out_rdy == 1'b1, "R3 low polarity idle high", out_rdy, 1);
    @(negedge clk);
    in_valid = 1'b1; in_i = 10'h0F0; in_q = 10'h30C;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_rdy == 1'b0, "R3 low polarity active low", out_rdy, 0);
    @(negedge clk);
    chk(out_rdy == 1'b1, "R3 low polarity returns high", out_rdy, 1);
    cfg_rdy_hi = 1'b1;

    // R10 enables
    oe_i_n = 1'b1; oe_q_n = 1'b0;
    #1 chk(out_i_en == 1'b0 && out_q_en == 1'b1, "R10 I disabled only", {out_i_en, out_q_en}, 2'b01);
    oe_i_n = 1'b0; oe_q_n = 1'b1;
    #1 chk(out_i_en == 1'b1 && out_q_en == 1'b0, "R10 Q disabled only", {out_i_en, out_q_en}, 2'b10);
    oe_q_n = 1'b0;
    #1 chk(out_i_en && out_q_en, "R10 both enabled", {out_i_en, out_q_en}, 2'b11);

    // Serial mode: R6, R7 idle checks
    @(negedge clk);
    cfg_serial = 1'b1;
    @(negedge clk);
    begin
      logic s0;
      s0 = out_i[W-1];
      @(negedge clk);
      chk(out_i[W-1] == !s0, "R6 sclk toggles", out_i[W-1], !s0);
    end
    chk(out_i[W-2:1] == cfg_fill_i[W-2:1], "R7 I fill pins", out_i[W-2:1], cfg_fill_i[W-2:1]);
    chk(out_q[W-1:1] == cfg_fill_q[W-1:1], "R7 Q fill pins", out_q[W-1:1], cfg_fill_q[W-1:1]);
    chk(out_i[0] == 1'b0 && !out_rdy, "R4 data pins idle low", {out_i[0], out_rdy}, 0);
    cfg_fill_i = 10'h2A5; cfg_fill_q = 10'h15A;
    #1 chk((out_i & ~10'h201) == fill_exp_i(cfg_fill_i) && out_q[W-1:1] == cfg_fill_q[W-1:1],
           "R7 fill follows config", {out_i, out_q}, {fill_exp_i(cfg_fill_i), cfg_fill_q});

    // R4/R5 directed alternating word
    in_valid = 1'b1; in_i = 10'h2AA; in_q = 10'h155;
    ser_word(10'h2AA, 10'h155, 1'b0);
    expect_ser_idle("R4 idle after word");

    // R8: arrival during shift follows immediately
    in_valid = 1'b1; in_i = 10'h381; in_q = 10'h04E;
    bi = 10'h1C7; bq = 10'h2D2;
    fork
      ser_word(10'h381, 10'h04E, 1'b0);
      begin
        repeat (9) @(negedge clk);
        in_valid = 1'b1; in_i = bi; in_q = bq;
        @(negedge clk);
        in_valid = 1'b0;
      end
    join
    ser_word(bi, bq, 1'b1);
    expect_ser_idle("R8 idle after queued word");

    // R9: two arrivals during shift, only newest sent
    in_valid = 1'b1; in_i = 10'h0FF; in_q = 10'h300;
    ci = 10'h246; cq = 10'h1B9;
    fork
      ser_word(10'h0FF, 10'h300, 1'b0);
      begin
        repeat (8) @(negedge clk);
        in_valid = 1'b1; in_i = 10'h3C3; in_q = 10'h03C;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (5) @(negedge clk);
        in_valid = 1'b1; in_i = ci; in_q = cq;
        @(negedge clk);
        in_valid = 1'b0;
      end
    join
    ser_word(ci, cq, 1'b1);
    expect_ser_idle("R9 dropped sample never sent");

    // R3 active-low ready in serial
    cfg_rdy_hi = 1'b0;
    in_valid = 1'b1; in_i = 10'h111; in_q = 10'h2EE;
    ser_word(10'h111, 10'h2EE, 1'b0);
    expect_ser_idle("R3 serial low polarity idle");
    cfg_rdy_hi = 1'b1;

    // Random serial words
    for (int n = 0; n < 25; n++) begin
      ei = W'($urandom); eq = W'($urandom);
      repeat ($urandom % 4) @(negedge clk);
      in_valid = 1'b1; in_i = ei; in_q = eq;
      ser_word(ei, eq, 1'b0);
      expect_ser_idle("R4 random word idle");
    end

    // Back to parallel: ready inactive, bus shows last parallel word
    cfg_serial = 1'b0;
    #1 chk(out_i == 10'h0F0 && out_q == 10'h30C && out_rdy == 1'b0,
           "R2 parallel bus kept across serial use", {out_i, out_q}, {10'h0F0, 10'h30C});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule